// File: doc/BRIEF.md
# Chroma 4:2:2 Multiplexer with Sync Toggle

This block moves the two chroma components of a YCbCr pixel stream onto one shared 8-bit bus and back again. In the pack direction it takes a Cb and a Cr sample on every pixel. It averages them over groups of co-sited pixels: two pixels in 4:2:2 mode, four in 4:1:1 mode. It then sends the group averages as an alternating Cb/Cr sequence on the Cr bus. While a decimated mode is active, the Cb bus carries no data and is driven to all ones. In the unpack direction the shared bus arrives on the Cr input. Each received Cb or Cr value is latched and repeated on the per-pixel outputs until the next value of that component arrives. In 4:4:4 mode the two buses pass through unchanged in both directions.

An internal phase counter decides whether the current cycle is a Cb slot or a Cr slot. A rising edge on the chroma-sync input forces the counter back to the start of a group, which is always a Cb slot. Holding the sync input high does nothing further. Every output is registered, so a result appears one clock after the inputs that produce it. The mode and direction inputs are expected to stay fixed while a stream is running. Mode code 3 behaves as 4:4:4.

Top module: `chroma_mux_top`

## Requirements
- R1: While the synchronous reset is high, both output buses are 0 after each clock edge.
- R2: In 4:4:4 mode (mode 0) with direction 0, the Cb and Cr outputs equal the Cb and Cr inputs of the previous cycle.
- R3: In 4:2:2 (mode 1) or 4:1:1 (mode 2) with direction 0, the Cb output is 8'hFF on every cycle after the first clock edge out of reset.
- R4: A rising edge of the sync input (low in the previous cycle, high now) makes that cycle phase 0, which is a Cb slot and the start of a group. A sync level held high causes no further realignment.
- R5: In 4:2:2 pack, phase 0 carries Cb and phase 1 carries Cr. In each slot the Cr output shows the average of the last completed two-pixel group, rounded half up, computed as (a+b+1)>>1.
- R6: In 4:1:1 pack, phases 0 and 1 carry Cb and phases 2 and 3 carry Cr. Each value is the average of the last completed four-pixel group, computed as (sum+2)>>2.
- R7: A group cut short by a sync rising edge is discarded. The averages on the bus keep their previous values until a full group completes.
- R8: In 4:4:4 mode with direction 1, the outputs equal the inputs of the previous cycle.
- R9: In 4:2:2 unpack (direction 1), the Cr-bus input is taken as Cb in phase 0 and as Cr in phase 1. Each output holds its latest latched value, and the Cb input has no effect.
- R10: In 4:1:1 unpack, Cb is latched in phase 0 and Cr in phase 2. Bus samples in phases 1 and 3 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 0 = 4:4:4, 1 = 4:2:2, 2 = 4:1:1, 3 = as 4:4:4 |
| dir_i | input | 1 | 0 = pack (per-pixel to shared bus), 1 = unpack |
| csync_i | input | 1 | Chroma sync; its rising edge realigns the phase |
| cb_i | input | 8 | Cb input (per-pixel Cb when packing, or 4:4:4 Cb) |
| cr_i | input | 8 | Cr input, or the shared chroma bus when unpacking |
| cb_o | output | 8 | Cb output (all ones while packing in a decimated mode) |
| cr_o | output | 8 | Cr output, or the shared chroma bus when packing |

## Verification
The hardest case to reach is a sync rising edge that arrives in the middle of a group. The accumulated partial sums must then be dropped while the bus keeps showing the older averages. The stimulus first runs complete groups with distinct values, so that the held averages are known. It then raises sync again part-way through a group, which requires first dropping it for a cycle, and checks that the next slots still carry the earlier averages. A long high sync level is also driven across several groups to show that a level alone causes no realignment.

// File: rtl/chroma_mux_pkg.sv
package chroma_mux_pkg;

    localparam int unsigned CHROMA_W = 8;

    typedef enum logic [1:0] {
        CM_444 = 2'd0,
        CM_422 = 2'd1,
        CM_411 = 2'd2,
        CM_RSV = 2'd3
    } cmode_e;

    // Last phase index of a co-sited group for a mode.
    function automatic logic [1:0] last_phase(input cmode_e m);
        case (m)
            CM_422:  return 2'd1;
            CM_411:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // Whether the mode decimates chroma.
    function automatic logic is_decim(input cmode_e m);
        return (m == CM_422) || (m == CM_411);
    endfunction

    // Whether a phase is a Cr slot on the shared bus.
    function automatic logic is_cr_slot(input cmode_e m, input logic [1:0] ph);
        if (m == CM_411) return ph[1];
        return ph[0];
    endfunction

    // Phase at which Cr begins in a group.
    function automatic logic [1:0] cr_start(input cmode_e m);
        if (m == CM_411) return 2'd2;
        return 2'd1;
    endfunction

endpackage

// File: rtl/chroma_phase.sv
module chroma_phase
    import chroma_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmode_e     mode,
    input  logic       csync_i,
    output logic [1:0] cur_ph,
    output logic       sync_rise
);

    logic       sync_q;
    logic [1:0] ph_q;
    logic [1:0] ph_nxt;

    assign sync_rise = csync_i & ~sync_q;
    assign cur_ph    = sync_rise ? 2'd0 : ph_q;

    always_comb begin
        if (cur_ph >= last_phase(mode)) ph_nxt = 2'd0;
        else                            ph_nxt = cur_ph + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            ph_q   <= 2'd0;
        end else begin
            sync_q <= csync_i;
            ph_q   <= ph_nxt;
        end
    end

    // R4: an edge starts a group, so the following cycle is phase 1
    p_rise_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_rise && is_decim(mode) && $stable(mode)) |=> (ph_q == 2'd1));

    // R5: a stable 4:2:2 run never leaves phases 0 and 1
    p_range_422_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_422 && $past(mode) == CM_422 && $past(!rst)) |-> (ph_q <= 2'd1));

endmodule

// File: rtl/chroma_pack.sv
module chroma_pack
    import chroma_mux_pkg::*;
#(
    parameter int unsigned DW = CHROMA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmode_e        mode,
    input  logic [1:0]    cur_ph,
    input  logic [DW-1:0] cb_i,
    input  logic [DW-1:0] cr_i,
    output logic [DW-1:0] held_cb,
    output logic [DW-1:0] held_cr
);

    localparam int unsigned SW   = DW + 2;
    localparam int unsigned NCMP = 2;

    logic [DW-1:0] comp_in   [NCMP];
    logic [DW-1:0] comp_held [NCMP];
    logic          group_end;

    assign comp_in[0] = cb_i;
    assign comp_in[1] = cr_i;
    assign held_cb    = comp_held[0];
    assign held_cr    = comp_held[1];
    assign group_end  = is_decim(mode) && (cur_ph == last_phase(mode));

    for (genvar c = 0; c < NCMP; c++) begin : g_comp
        logic [SW-1:0] sum_q;
        logic [SW-1:0] sum_cur;
        logic [SW-1:0] rnd;
        logic [DW-1:0] avg;
        logic [DW-1:0] held_q;

        assign sum_cur = (cur_ph == 2'd0) ? SW'(comp_in[c]) : (sum_q + SW'(comp_in[c]));

        always_comb begin
            if (mode == CM_411) begin
                rnd = sum_cur + SW'(2);
                avg = rnd[DW+1:2];
            end else begin
                rnd = sum_cur + SW'(1);
                avg = rnd[DW:1];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q  <= '0;
                held_q <= '0;
            end else begin
                sum_q <= sum_cur;
                if (group_end) held_q <= avg;
            end
        end

        assign comp_held[c] = held_q;
    end

    // R7: held averages only move at the end of a full group
    p_held_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !group_end |=> ($stable(held_cb) && $stable(held_cr)));

endmodule

// File: rtl/chroma_unpack.sv
module chroma_unpack
    import chroma_mux_pkg::*;
#(
    parameter int unsigned DW = CHROMA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmode_e        mode,
    input  logic [1:0]    cur_ph,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] nxt_cb,
    output logic [DW-1:0] nxt_cr
);

    logic [DW-1:0] hold_cb_q;
    logic [DW-1:0] hold_cr_q;
    logic          take_cb;
    logic          take_cr;

    assign take_cb = is_decim(mode) && (cur_ph == 2'd0);
    assign take_cr = is_decim(mode) && (cur_ph == cr_start(mode));
    assign nxt_cb  = take_cb ? bus_i : hold_cb_q;
    assign nxt_cr  = take_cr ? bus_i : hold_cr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cb_q <= '0;
            hold_cr_q <= '0;
        end else begin
            hold_cb_q <= nxt_cb;
            hold_cr_q <= nxt_cr;
        end
    end

    // R10: repeat slots of 4:1:1 leave both holds untouched
    p_odd_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_411 && cur_ph[0]) |=> ($stable(hold_cb_q) && $stable(hold_cr_q)));

endmodule

// File: rtl/chroma_mux_top.sv
module chroma_mux_top
    import chroma_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       dir_i,
    input  logic       csync_i,
    input  logic [7:0] cb_i,
    input  logic [7:0] cr_i,
    output logic [7:0] cb_o,
    output logic [7:0] cr_o
);

    localparam int unsigned DW = CHROMA_W;

    typedef struct packed {
        logic [DW-1:0] cb;
        logic [DW-1:0] cr;
    } cpair_t;

    cmode_e        mode;
    logic [1:0]    cur_ph;
    logic          sync_rise;
    logic [DW-1:0] held_cb, held_cr;
    logic [DW-1:0] un_cb, un_cr;
    cpair_t        out_nxt, out_q;

    assign mode = cmode_e'(mode_i);

    chroma_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .csync_i   (csync_i),
        .cur_ph    (cur_ph),
        .sync_rise (sync_rise)
    );

    chroma_pack #(.DW(DW)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .cur_ph  (cur_ph),
        .cb_i    (cb_i),
        .cr_i    (cr_i),
        .held_cb (held_cb),
        .held_cr (held_cr)
    );

    chroma_unpack #(.DW(DW)) u_unpack (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .cur_ph (cur_ph),
        .bus_i  (cr_i),
        .nxt_cb (un_cb),
        .nxt_cr (un_cr)
    );

    always_comb begin
        if (!is_decim(mode)) begin
            out_nxt.cb = cb_i;
            out_nxt.cr = cr_i;
        end else if (!dir_i) begin
            out_nxt.cb = '1;
            out_nxt.cr = is_cr_slot(mode, cur_ph) ? held_cr : held_cb;
        end else begin
            out_nxt.cb = un_cb;
            out_nxt.cr = un_cr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_nxt;
    end

    assign cb_o = out_q.cb;
    assign cr_o = out_q.cr;

    // R1: reset clears both buses
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (cb_o == '0 && cr_o == '0));

    // R3: idle Cb bus is all ones while packing a decimated stream
    p_cb_idle_ones_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(is_decim(mode)) && $past(!dir_i)) |-> (cb_o == '1));

    // R2: 4:4:4 pack passes both buses with one register of latency
    p_pass444_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!is_decim(mode)) && $past(!dir_i))
            |-> (cb_o == $past(cb_i) && cr_o == $past(cr_i)));

    // R4: a rising edge in pack mode puts a Cb-slot value on the bus
    p_rise_cb_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_rise && is_decim(mode) && !dir_i) |=> (cr_o == $past(held_cb)));

endmodule

// File: tb/chroma_mux_top_tb_top.sv
module chroma_mux_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic       dir_i = 1'b0;
    logic       csync_i = 1'b0;
    logic [7:0] cb_i = 8'd0;
    logic [7:0] cr_i = 8'd0;
    logic [7:0] cb_o, cr_o;

    always #10 clk = ~clk;   // 50 MHz

    chroma_mux_top dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .dir_i(dir_i),
        .csync_i(csync_i), .cb_i(cb_i), .cr_i(cr_i), .cb_o(cb_o), .cr_o(cr_o)
    );

    typedef struct {
        logic [7:0] cb;
        logic [7:0] cr;
        string      tcb;
        string      tcr;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference model state
    bit       m_prev;
    int       m_ph, m_scb, m_scr, m_hcb, m_hcr, m_rcb, m_rcr;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_ph = 0; m_scb = 0; m_scr = 0;
        m_hcb = 0; m_hcr = 0; m_rcb = 0; m_rcr = 0;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic d);
        @(negedge clk);
        rst = 1'b1; mode_i = m; dir_i = d; csync_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // Drive one pixel cycle and push what the outputs must show after the edge.
    task automatic drive(input bit s, input logic [7:0] cb, input logic [7:0] cr,
                         input string tcb, input string tcr);
        exp_t e;
        bit   rise, decim, crslot;
        int   cp, last, m;
        m      = int'(mode_i);
        rise   = s && !m_prev;
        cp     = rise ? 0 : m_ph;
        last   = (m == 1) ? 1 : (m == 2) ? 3 : 0;
        decim  = (m == 1) || (m == 2);
        crslot = (m == 2) ? ((cp & 2) != 0) : ((cp & 1) != 0);
        e.tcb = tcb; e.tcr = tcr;
        if (!decim) begin
            e.cb = cb; e.cr = cr;
        end else if (!dir_i) begin
            e.cb = 8'hFF;
            e.cr = crslot ? 8'(m_hcr) : 8'(m_hcb);
        end
        if (decim) begin
            m_scb = (cp == 0) ? int'(cb) : m_scb + int'(cb);
            m_scr = (cp == 0) ? int'(cr) : m_scr + int'(cr);
            if (cp == last) begin
                m_hcb = (m == 2) ? (m_scb + 2) / 4 : (m_scb + 1) / 2;
                m_hcr = (m == 2) ? (m_scr + 2) / 4 : (m_scr + 1) / 2;
            end
            if (cp == 0) m_rcb = cr;
            if (cp == ((m == 2) ? 2 : 1)) m_rcr = cr;
            if (dir_i) begin
                e.cb = 8'(m_rcb); e.cr = 8'(m_rcr);
            end
        end
        m_ph   = (cp >= last) ? 0 : cp + 1;
        m_prev = s;
        exp_q.push_back(e);
        csync_i = s; cb_i = cb; cr_i = cr;
        @(negedge clk);
    endtask

    // monitor: sample after each edge, away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(cb_o, e.cb, e.tcb);
                check(cr_o, e.cr, e.tcr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'd0, 1'b0);
        check(cb_o, 8'h00, "R1 cb");
        check(cr_o, 8'h00, "R1 cr");

        // R2: 4:4:4 pack pass-through
        for (int i = 0; i < 8; i++)
            drive(i[0], 8'(i * 37 + 5), 8'(255 - i * 29), "R2 cb", "R2 cr");

        // R5 with R3: 4:2:2 pack, rounding corners
        do_reset(2'd1, 1'b0);
        drive(1, 8'd10, 8'd255, "R3", "R5");
        drive(0, 8'd13, 8'd254, "R3", "R5");   // avg cb 12, cr 255
        drive(0, 8'd0,  8'd100, "R3", "R5");
        drive(0, 8'd1,  8'd101, "R3", "R5");   // avg cb 1, cr 101
        drive(0, 8'd200, 8'd7,  "R3", "R5");
        drive(0, 8'd201, 8'd8,  "R3", "R5");
        drive(0, 8'd255, 8'd0,  "R3", "R5");
        drive(0, 8'd255, 8'd0,  "R3", "R5");
        drive(0, 8'd50, 8'd60,  "R3", "R5");

        // R4: long high level does not realign; R7: mid-group edge discards
        drive(1, 8'd90, 8'd91,  "R3", "R4");   // edge, phase 0
        drive(1, 8'd92, 8'd93,  "R3", "R4");
        drive(1, 8'd94, 8'd95,  "R3", "R4");   // level only, phase 0 by count
        drive(0, 8'd96, 8'd97,  "R3", "R4");
        drive(0, 8'd20, 8'd30,  "R3", "R7");   // phase 0 of a group
        drive(1, 8'd44, 8'd66,  "R3", "R7");   // edge mid-group: restart
        drive(0, 8'd46, 8'd68,  "R3", "R7");
        drive(0, 8'd1,  8'd2,   "R3", "R7");
        drive(0, 8'd3,  8'd4,   "R3", "R7");

        // R6: 4:1:1 pack
        do_reset(2'd2, 1'b0);
        drive(1, 8'd10, 8'd200, "R3", "R6");
        drive(0, 8'd11, 8'd201, "R3", "R6");
        drive(0, 8'd12, 8'd202, "R3", "R6");
        drive(0, 8'd12, 8'd203, "R3", "R6");   // cb 45 -> 11, cr 806 -> 202
        for (int i = 0; i < 12; i++)
            drive(0, 8'(i * 19 + 3), 8'(250 - i * 17), "R3", "R6");
        drive(0, 8'd77, 8'd88,  "R3", "R7");
        drive(1, 8'd99, 8'd11,  "R3", "R7");   // edge at phase 1: group dropped
        drive(0, 8'd1,  8'd1,   "R3", "R7");
        drive(0, 8'd2,  8'd2,   "R3", "R7");
        drive(0, 8'd3,  8'd3,   "R3", "R7");
        drive(0, 8'd4,  8'd4,   "R3", "R6");

        // R8: 4:4:4 unpack
        do_reset(2'd0, 1'b1);
        for (int i = 0; i < 6; i++)
            drive(i[1], 8'(i * 41 + 1), 8'(i * 13 + 9), "R8 cb", "R8 cr");

        // R9: 4:2:2 unpack with garbage on the Cb input
        do_reset(2'd1, 1'b1);
        drive(1, 8'hAA, 8'd31, "R9 cb", "R9 cr");
        for (int i = 0; i < 9; i++)
            drive(0, 8'(i * 53), 8'(i * 23 + 40), "R9 cb", "R9 cr");
        drive(1, 8'h55, 8'd7, "R9 cb", "R9 cr");
        drive(0, 8'h66, 8'd8, "R9 cb", "R9 cr");

        // R10: 4:1:1 unpack, repeat slots ignored
        do_reset(2'd2, 1'b1);
        drive(1, 8'h00, 8'd120, "R10 cb", "R10 cr");
        drive(0, 8'hFF, 8'd5,   "R10 cb", "R10 cr");
        drive(0, 8'h12, 8'd140, "R10 cb", "R10 cr");
        drive(0, 8'h34, 8'd6,   "R10 cb", "R10 cr");
        for (int i = 0; i < 8; i++)
            drive(0, 8'(i * 7), 8'(i * 31 + 2), "R10 cb", "R10 cr");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule